// File: doc/BRIEF.md
# Teletext Bit Pacer

This block paces the serial transfer of teletext data for 625-line, 50-field broadcast systems. It uses a two-wire exchange. The block pulses a request output at the start of every bit slot, and a data source answers on a serial input line. The block captures that line a fixed number of cycles later. It then hands the captured bit on with a one-cycle valid strobe.

The clock runs at 27 MHz, which is twice a 13.5 MHz sample rate. At that clock the teletext bit rate is not a whole number of cycles. Slots are therefore grouped by 37. Positions 10, 19, 28 and 37 of each group last 3 clocks and every other position lasts 4 clocks, so one group takes 144 clocks.

A mode input turns the request output into a bit-rate clock. A line-enable input gates all activity on lines that carry no teletext. A line-start strobe realigns the slot count at the start of a line.

Top module: `txt_bit_pacer`

## Requirements
- R1: While `rst_n` is low, `fetch_req`, `bit_vld` and `bit_out` are 0. The slot counter leaves reset at position 1, so the first slot after enabling lasts 4 clocks.
- R2: Slots at positions 10, 19, 28 and 37 last 3 clocks. Every other position from 1 to 37 lasts 4 clocks.
- R3: After position 37 the count returns to position 1. Each group of 37 slots spans exactly 144 clocks and carries 37 requests.
- R4: With `clk_out_mode` = 0, `fetch_req` is high for exactly one clock per slot, in the cycle after the slot begins.
- R5: `bit_vld` pulses for one clock two cycles after each request cycle. In that cycle `bit_out` shows the value `ser_din` had in the cycle just after the request. Between pulses `bit_out` holds its value.
- R6: A high `line_start` in cycle s restarts the count at position 1. The first new request appears in cycle s+2. A capture still pending when the strobe arrives produces no `bit_vld`.
- R7: If `line_en` is 0 in a cycle, `fetch_req` and `bit_vld` are 0 in the next cycle, pending captures are dropped, and the count is held at position 1. If `line_en` rises in cycle a, the first request appears in cycle a+1.
- R8: With `clk_out_mode` = 1, `fetch_req` is high for the first floor(L/2) clocks of each slot of length L, delayed by one cycle, and low for the rest of the slot. That gives 2 high and 2 low for 4-clock slots, and 1 high and 2 low for 3-clock slots.
- R9: With `clk_out_mode` = 1, capture timing and `bit_vld` placement relative to each slot start match those of request mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz clock, twice the sample rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_out_mode | input | 1 | 0: one-clock request per slot; 1: bit-rate clock on `fetch_req` |
| line_en | input | 1 | High on lines that carry teletext |
| line_start | input | 1 | One-cycle strobe that realigns the slot count to position 1 |
| ser_din | input | 1 | Serial data answered by the source |
| fetch_req | output | 1 | Request pulse or bit-rate clock toward the source |
| bit_vld | output | 1 | One-cycle strobe marking a fresh captured bit |
| bit_out | output | 1 | Last captured data bit |

## Verification
A realignment strobe can land in the same cycle in which a capture triggered by the previous request is due to complete. The bench provokes this by watching for a request and then raising `line_start` in the following cycle. It then requires that the doomed capture never raises `bit_vld`, and that the fresh request and its capture fall exactly two and four cycles after the strobe. The same kind of collision with `line_en` falling is also provoked. In addition, each table scenario issues its restart at an arbitrary slot phase left over from the previous run.

// File: rtl/txt_pace_pkg.sv
package txt_pace_pkg;

  // A slot is short when its 1-based position sits one past a multiple of
  // the stride, excluding the very first position of the group.
  function automatic bit slot_is_short(input int pos, input int stride);
    return (pos > 1) && ((pos % stride) == 1);
  endfunction

  function automatic int slot_clks(input int pos, input int stride,
                                   input int long_clks, input int short_clks);
    return slot_is_short(pos, stride) ? short_clks : long_clks;
  endfunction

  // High time of the bit-rate clock inside a slot, rounded down.
  function automatic int slot_high_clks(input int len);
    return len / 2;
  endfunction

  function automatic int group_clks(input int bits, input int stride,
                                    input int long_clks, input int short_clks);
    int sum = 0;
    for (int p = 1; p <= bits; p++) begin
      sum += slot_clks(p, stride, long_clks, short_clks);
    end
    return sum;
  endfunction

endpackage

// File: rtl/txt_slot_timer.sv
module txt_slot_timer
  import txt_pace_pkg::*;
#(
  parameter int GROUP_BITS   = 37,
  parameter int SHORT_STRIDE = 9,
  parameter int LONG_CLKS    = 4,
  parameter int SHORT_CLKS   = 3,
  parameter int POS_W        = $clog2(GROUP_BITS + 1),
  parameter int CYC_W        = $clog2(LONG_CLKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  output logic [POS_W-1:0] pos,
  output logic             period_start,
  output logic             clock_hi
);

  logic [POS_W-1:0] pos_q;
  logic [CYC_W-1:0] cyc_q;
  int               cur_len;
  logic             at_last;
  logic             hold;

  always_comb begin
    cur_len      = slot_clks(int'(pos_q), SHORT_STRIDE, LONG_CLKS, SHORT_CLKS);
    at_last      = (int'(cyc_q) == cur_len - 1);
    hold         = !run || restart;
    period_start = !hold && (cyc_q == '0);
    clock_hi     = !hold && (int'(cyc_q) < slot_high_clks(cur_len));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= POS_W'(1);
      cyc_q <= '0;
    end else if (hold) begin
      pos_q <= POS_W'(1);
      cyc_q <= '0;
    end else if (at_last) begin
      cyc_q <= '0;
      pos_q <= (int'(pos_q) == GROUP_BITS) ? POS_W'(1) : pos_q + POS_W'(1);
    end else begin
      cyc_q <= cyc_q + CYC_W'(1);
    end
  end

  assign pos = pos_q;

endmodule

// File: rtl/txt_req_drive.sv
module txt_req_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_out_mode,
  input  logic period_start,
  input  logic clock_hi,
  output logic fetch_req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_req <= 1'b0;
    end else begin
      fetch_req <= clk_out_mode ? clock_hi : period_start;
    end
  end

endmodule

// File: rtl/txt_capture.sv
module txt_capture #(
  parameter int SAMPLE_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic period_start,
  input  logic ser_din,
  output logic bit_vld,
  output logic bit_out
);

  logic [SAMPLE_LAT-1:0] pipe_q;
  logic                  take;

  assign take = pipe_q[SAMPLE_LAT-1] && run && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q  <= '0;
      bit_vld <= 1'b0;
      bit_out <= 1'b0;
    end else begin
      if (!run || restart) begin
        pipe_q <= '0;
      end else begin
        pipe_q[0] <= period_start;
        for (int i = 1; i < SAMPLE_LAT; i++) begin
          pipe_q[i] <= pipe_q[i-1];
        end
      end
      bit_vld <= take;
      if (take) begin
        bit_out <= ser_din;
      end
    end
  end

endmodule

// File: rtl/txt_bit_pacer.sv
module txt_bit_pacer #(
  parameter int GROUP_BITS   = 37,
  parameter int SHORT_STRIDE = 9,
  parameter int LONG_CLKS    = 4,
  parameter int SHORT_CLKS   = 3,
  parameter int SAMPLE_LAT   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_out_mode,
  input  logic line_en,
  input  logic line_start,
  input  logic ser_din,
  output logic fetch_req,
  output logic bit_vld,
  output logic bit_out
);

  localparam int POS_W = $clog2(GROUP_BITS + 1);
  localparam int CYC_W = $clog2(LONG_CLKS);

  // Internal events brought out by name for the bound checker.
  logic [POS_W-1:0] slot_pos;
  logic             slot_start;
  logic             slot_hi;

  txt_slot_timer #(
    .GROUP_BITS  (GROUP_BITS),
    .SHORT_STRIDE(SHORT_STRIDE),
    .LONG_CLKS   (LONG_CLKS),
    .SHORT_CLKS  (SHORT_CLKS),
    .POS_W       (POS_W),
    .CYC_W       (CYC_W)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (line_en),
    .restart     (line_start),
    .pos         (slot_pos),
    .period_start(slot_start),
    .clock_hi    (slot_hi)
  );

  txt_req_drive u_req (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_out_mode(clk_out_mode),
    .period_start(slot_start),
    .clock_hi    (slot_hi),
    .fetch_req   (fetch_req)
  );

  txt_capture #(
    .SAMPLE_LAT(SAMPLE_LAT)
  ) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (line_en),
    .restart     (line_start),
    .period_start(slot_start),
    .ser_din     (ser_din),
    .bit_vld     (bit_vld),
    .bit_out     (bit_out)
  );

endmodule

// File: rtl/txt_bit_pacer_chk.sv
module txt_bit_pacer_chk
  import txt_pace_pkg::*;
#(
  parameter int GROUP_BITS   = 37,
  parameter int SHORT_STRIDE = 9,
  parameter int LONG_CLKS    = 4,
  parameter int SHORT_CLKS   = 3,
  parameter int SAMPLE_LAT   = 2,
  parameter int POS_W        = $clog2(GROUP_BITS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clk_out_mode,
  input logic             line_en,
  input logic             line_start,
  input logic             ser_din,
  input logic             fetch_req,
  input logic             bit_vld,
  input logic             bit_out,
  input logic [POS_W-1:0] slot_pos,
  input logic             slot_start
);

  localparam int GRP_CLKS = group_clks(GROUP_BITS, SHORT_STRIDE, LONG_CLKS, SHORT_CLKS);

  logic [7:0]  since_start;
  logic [15:0] gap_cnt;
  logic        gap_ok;
  logic [15:0] grp_cnt;
  logic        grp_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_start <= 8'hFF;
      gap_cnt     <= '0;
      gap_ok      <= 1'b0;
      grp_cnt     <= '0;
      grp_ok      <= 1'b0;
    end else begin
      if (slot_start) since_start <= '0;
      else if (since_start != 8'hFF) since_start <= since_start + 8'd1;

      if (!line_en || line_start) begin
        gap_ok <= 1'b0;
        grp_ok <= 1'b0;
      end else begin
        if (slot_start) begin
          gap_cnt <= 16'd1;
          gap_ok  <= 1'b1;
        end else begin
          gap_cnt <= gap_cnt + 16'd1;
        end
        if (slot_start && slot_pos == POS_W'(1)) begin
          grp_cnt <= 16'd1;
          grp_ok  <= 1'b1;
        end else begin
          grp_cnt <= grp_cnt + 16'd1;
        end
      end
    end
  end

  // R2: consecutive slot starts are a long or a short slot apart
  p_slot_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start && gap_ok |-> (gap_cnt == 16'(LONG_CLKS) || gap_cnt == 16'(SHORT_CLKS)));

  // R3: a full group of slots spans the fixed clock count
  p_group_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start && slot_pos == POS_W'(1) && grp_ok |-> grp_cnt == 16'(GRP_CLKS));

  // R4: a request in request mode is a single clock wide
  p_req_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_out_mode && fetch_req |=> !fetch_req);

  // R5 and R9: valid strobe arrives a fixed latency after the slot start
  p_vld_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |-> since_start == 8'(SAMPLE_LAT));

  // R5: the captured bit is the serial input of the previous cycle
  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |-> bit_out == $past(ser_din));

  // R6: a restart strobe suppresses any capture still in flight
  p_restart_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !bit_vld ##1 !bit_vld);

  // R7: an idle line yields no request and no strobe
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !line_en |=> !fetch_req && !bit_vld);

  // R8: in clock mode each rising edge follows a slot start
  p_clock_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_req) && $past(clk_out_mode) && $past(clk_out_mode, 2) |-> $past(slot_start));

endmodule

bind txt_bit_pacer txt_bit_pacer_chk #(
  .GROUP_BITS  (GROUP_BITS),
  .SHORT_STRIDE(SHORT_STRIDE),
  .LONG_CLKS   (LONG_CLKS),
  .SHORT_CLKS  (SHORT_CLKS),
  .SAMPLE_LAT  (SAMPLE_LAT),
  .POS_W       (POS_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clk_out_mode(clk_out_mode),
  .line_en     (line_en),
  .line_start  (line_start),
  .ser_din     (ser_din),
  .fetch_req   (fetch_req),
  .bit_vld     (bit_vld),
  .bit_out     (bit_out),
  .slot_pos    (slot_pos),
  .slot_start  (slot_start)
);

// File: tb/sim_txt_bit_pacer.sv
module sim_txt_bit_pacer;

  localparam int W     = 292;
  localparam int NSCEN = 6;
  // Vector: [13] clock mode, [12:5] data seed, [4:2] expected high clocks
  // in a 4-clock slot, [1:0] expected high clocks in a 3-clock slot.
  localparam logic [13:0] SCEN [NSCEN] = '{
    {1'b0, 8'hA5, 3'd1, 2'd1},
    {1'b1, 8'h3C, 3'd2, 2'd1},
    {1'b0, 8'hFF, 3'd1, 2'd1},
    {1'b0, 8'h00, 3'd1, 2'd1},
    {1'b1, 8'h96, 3'd2, 2'd1},
    {1'b0, 8'h5B, 3'd1, 2'd1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_out_mode = 1'b0;
  logic       line_en = 1'b0;
  logic       line_start = 1'b0;
  logic [7:0] seed = 8'h00;
  int         tb_cyc = 0;
  logic       ser_din;
  logic       fetch_req;
  logic       bit_vld;
  logic       bit_out;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic rq  [W];
  logic vd  [W];
  logic bo  [W];
  logic erq [W];
  logic evd [W];
  logic ebo [W];

  always #4 clk = ~clk;
  always @(posedge clk) tb_cyc <= tb_cyc + 1;

  function automatic logic data_fn(input int c, input logic [7:0] sd);
    return sd[c[2:0]] ^ c[5];
  endfunction

  function automatic bit is_short_bit(input int p);
    return (p == 10) || (p == 19) || (p == 28) || (p == 37);
  endfunction

  assign ser_din = data_fn(tb_cyc, seed);

  txt_bit_pacer u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_out_mode(clk_out_mode),
    .line_en     (line_en),
    .line_start  (line_start),
    .ser_din     (ser_din),
    .fetch_req   (fetch_req),
    .bit_vld     (bit_vld),
    .bit_out     (bit_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_scenario(input logic [13:0] v);
    int s, t, k, p, len, hi;
    int bad_req, bad_vld, bad_dat, at_req, at_vld, at_dat;
    int rise1, rise2;
    @(posedge clk); #1;
    clk_out_mode = v[13];
    seed         = v[12:5];
    line_en      = 1'b1;
    line_start   = 1'b1;
    s            = tb_cyc;
    @(posedge clk); #1;
    line_start = 1'b0;
    for (int r = 0; r < W; r++) begin
      erq[r] = 1'b0; evd[r] = 1'b0; ebo[r] = 1'b0;
    end
    t = 1; k = 0;
    while (t < W) begin
      p   = (k % 37) + 1;
      len = is_short_bit(p) ? 3 : 4;
      hi  = is_short_bit(p) ? int'(v[1:0]) : int'(v[4:2]);
      for (int j = 1; j <= hi; j++) if (t + j < W) erq[t+j] = 1'b1;
      if (t + 3 < W) begin
        evd[t+3] = 1'b1;
        ebo[t+3] = data_fn(s + t + 2, v[12:5]);
      end
      t += len;
      k++;
    end
    for (int r = 1; r < W; r++) begin
      @(negedge clk);
      rq[r] = fetch_req; vd[r] = bit_vld; bo[r] = bit_out;
    end
    bad_req = 0; bad_vld = 0; bad_dat = 0; at_req = 0; at_vld = 0; at_dat = 0;
    rise1 = 0; rise2 = 0;
    for (int r = 1; r < W; r++) begin
      if (rq[r] !== erq[r]) begin if (bad_req == 0) at_req = r; bad_req++; end
      if (vd[r] !== evd[r]) begin if (bad_vld == 0) at_vld = r; bad_vld++; end
      if (evd[r] && bo[r] !== ebo[r]) begin if (bad_dat == 0) at_dat = r; bad_dat++; end
      if (r >= 2 && r <= 145 && rq[r] && !rq[r-1]) rise1++;
      if (r >= 146 && r <= 289 && rq[r] && !rq[r-1]) rise2++;
    end
    if (v[13])
      check(bad_req == 0, $sformatf("R8 clock waveform, first bad cycle %0d", at_req),
            int'(rq[at_req]), int'(erq[at_req]));
    else
      check(bad_req == 0, $sformatf("R2 R4 request pattern, first bad cycle %0d", at_req),
            int'(rq[at_req]), int'(erq[at_req]));
    check(bad_vld == 0, $sformatf("R5 R9 strobe timing, first bad cycle %0d", at_vld),
          int'(vd[at_vld]), int'(evd[at_vld]));
    check(bad_dat == 0, $sformatf("R5 captured data, first bad cycle %0d", at_dat),
          int'(bo[at_dat]), int'(ebo[at_dat]));
    check(rise1 == 37, "R3 slots in first group", rise1, 37);
    check(rise2 == 37, "R3 slots in second group", rise2, 37);
    check(rq[1] == 1'b0 && rq[2] == 1'b1, "R6 first request two cycles after restart",
          int'({rq[1], rq[2]}), 1);
  endtask

  initial begin
    int quiet, a;
    repeat (3) @(negedge clk);
    check(fetch_req == 1'b0 && bit_vld == 1'b0 && bit_out == 1'b0, "R1 outputs in reset",
          int'({fetch_req, bit_vld, bit_out}), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R7: idle line, input toggling
    quiet = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (fetch_req || bit_vld) quiet++;
    end
    check(quiet == 0, "R7 idle line emits nothing", quiet, 0);

    // R7 and R1: first slot after enabling
    @(posedge clk); #1;
    seed    = 8'h6D;
    line_en = 1'b1;
    a       = tb_cyc;
    for (int r = 0; r <= 7; r++) begin
      @(negedge clk);
      rq[r] = fetch_req; vd[r] = bit_vld; bo[r] = bit_out;
    end
    check(rq[0] == 1'b0 && rq[1] == 1'b1, "R7 request one cycle after enable",
          int'({rq[0], rq[1]}), 1);
    check(!rq[2] && !rq[3] && !rq[4] && rq[5], "R1 first slot lasts four clocks",
          int'({rq[2], rq[3], rq[4], rq[5]}), 1);
    check(vd[3] == 1'b1 && bo[3] == data_fn(a + 2, 8'h6D), "R5 first capture",
          int'({vd[3], bo[3]}), int'({1'b1, data_fn(a + 2, 8'h6D)}));

    // R7: enable falls while a capture is pending
    do @(negedge clk); while (!fetch_req);
    @(posedge clk); #1;
    line_en = 1'b0;
    quiet = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (fetch_req || bit_vld) quiet++;
    end
    check(quiet == 0, "R7 pending capture dropped on disable", quiet, 0);

    // R6: restart collides with a pending capture
    @(posedge clk); #1;
    line_en = 1'b1;
    do @(negedge clk); while (!fetch_req);
    @(posedge clk); #1;
    line_start = 1'b1;
    @(posedge clk); #1;
    line_start = 1'b0;
    a = tb_cyc;
    for (int r = 2; r <= 6; r++) begin
      @(negedge clk);
      rq[r] = fetch_req; vd[r] = bit_vld; bo[r] = bit_out;
    end
    check(!vd[2] && !vd[3] && !vd[4], "R6 pending capture dropped on restart",
          int'({vd[2], vd[3], vd[4]}), 0);
    check(rq[3] && !rq[4], "R6 new request after restart", int'({rq[3], rq[4]}), 2);
    check(vd[5] && bo[5] == data_fn(a + 2, seed), "R6 capture after restart",
          int'({vd[5], bo[5]}), int'({1'b1, data_fn(a + 2, seed)}));

    // Table of scenarios, each restarting at an arbitrary slot phase
    for (int n = 0; n < NSCEN; n++) run_scenario(SCEN[n]);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule